// File: doc/BRIEF.md
# Three-Phase Bridge Gate Protection Core

This block sits between a motor-control PWM source and the pre-driver of a six-switch three-phase bridge. Each phase has one high-side and one low-side active-high command. The block turns them into six registered gate enables. It refuses to turn on both switches of a leg, removes drive when supplies sag or current runs away, and reports overcurrent on an active-low fault line. Dead time is not produced here. The controller must supply it.

Every command and status input is asynchronous and passes through a two-flop synchronizer first. Each command is then qualified by a filter, so a level change must persist for a configurable number of cycles before it counts. This drops pulses shorter than about a microsecond. An overcurrent flag opens a fault window that ends a fixed, parameterized number of cycles after the flag was last seen high. Undervoltage on the main supply blocks all gates only while it lasts. Undervoltage on one high-side supply blocks only that phase's high gate, and that block holds until the phase's high command has been seen low. Undervoltage never drives the fault line.

Timing parameters are given in physical units together with the clock rate: `CLK_MHZ`, `FILTER_NS` and `RECOVER_US`. The cycle counts are derived from them.

Top module: `bridge_guard`

## Requirements
- R1: With no fault or undervoltage, a phase whose only asserted command is high drives only `gate_hi` of that phase. A phase whose only asserted command is low drives only `gate_lo`. A phase with both commands low drives neither gate.
- R2: When both commands of a phase are asserted, both gates of that phase are off. The other phases are unaffected.
- R3: While the synchronized overcurrent flag is high, all six gates are off and `fault_n` is 0.
- R4: After `oc_flag` falls, `fault_n` returns to 1 and gates follow the commands again exactly RECOVER+3 clock edges later, where RECOVER = CLK_MHZ*RECOVER_US. Any new sighting of the flag inside the window restarts this count from its next fall.
- R5: While `uv_main` is high, all six gates are off and `fault_n` stays 1. Gates follow the held commands again once it clears.
- R6: `uv_hi[i]` high turns off only `gate_hi[i]`. Low gates and other phases are unaffected, and `fault_n` stays 1.
- R7: After `uv_hi[i]` clears, `gate_hi[i]` stays off while `hi_cmd[i]` is held high. It can turn on again only after `hi_cmd[i]` has been qualified low at least once.
- R8: Low gates carry no latched undervoltage state. A low command held high through a `uv_main` event drives its gate again as soon as the flag clears.
- R9: A command level that lasts fewer than FILTER = CLK_MHZ*FILTER_NS/1000 cycles, whether an on pulse or an off gap, has no effect on the gates. A level that lasts FILTER+2 cycles or more takes effect.
- R10: During and right after synchronous reset `rst`, all gates are 0 and `fault_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hi_cmd | input | 3 | High-side PWM commands, bit i = phase i |
| lo_cmd | input | 3 | Low-side PWM commands, bit i = phase i |
| oc_flag | input | 1 | Overcurrent comparator flag, active high |
| uv_main | input | 1 | Main pre-driver supply undervoltage, active high |
| uv_hi | input | 3 | High-side supply undervoltage per phase, active high |
| gate_hi | output | 3 | High-side gate enables |
| gate_lo | output | 3 | Low-side gate enables |
| fault_n | output | 1 | Overcurrent fault indication, active low |

## Verification
A recovery counter that is loaded or decremented wrongly shows as `fault_n` rising one or more edges off from RECOVER+3 after the overcurrent flag falls. A counter that does not reload shows as the window closing early after a second trip. A high-side hold bit that sticks or never sets appears within a few cycles of `uv_hi` clearing: `gate_hi` either stays dark after the command has dropped and returned, or switches on again with the command still held high. A filter counter that is not cleared shows as a short pulse reaching a gate, or as a valid level arriving late or never, within FILTER+3 cycles.

// File: rtl/bridge_guard_pkg.sv
package bridge_guard_pkg;
  localparam int PHASES = 3;

  function automatic int cw_of(input int maxval);
    return (maxval < 2) ? 1 : $clog2(maxval + 1);
  endfunction
endpackage

// File: rtl/bg_sync.sv
module bg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/bg_qual_filter.sv
module bg_qual_filter #(
  parameter int CYCLES = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  generate
    if (CYCLES <= 1) begin : g_pass
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= d;
      end
    end else begin : g_count
      localparam int CW = bridge_guard_pkg::cw_of(CYCLES - 1);
      localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);
      logic [CW-1:0] run;

      always_ff @(posedge clk) begin
        if (rst) begin
          q   <= 1'b0;
          run <= '0;
        end else if (d == q) begin
          run <= '0;
        end else if (run == LAST) begin
          q   <= d;
          run <= '0;
        end else begin
          run <= run + 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/bg_fault_timer.sv
module bg_fault_timer #(
  parameter int RECOVER = 3000000
) (
  input  logic clk,
  input  logic rst,
  input  logic trip,
  output logic active
);
  localparam int CW = bridge_guard_pkg::cw_of(RECOVER);
  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst)              left <= '0;
    else if (trip)        left <= CW'(RECOVER);
    else if (left != '0)  left <= left - 1'b1;
  end

  assign active = trip | (left != '0);
endmodule

// File: rtl/bg_phase_ctl.sv
module bg_phase_ctl (
  input  logic clk,
  input  logic rst,
  input  logic hcmd,
  input  logic lcmd,
  input  logic uv_hs,
  input  logic kill_all,
  output logic gate_hi,
  output logic gate_lo
);
  logic hs_hold;
  logic hs_block;
  logic lone_hi;
  logic lone_lo;

  always_ff @(posedge clk) begin
    if (rst)        hs_hold <= 1'b0;
    else if (uv_hs) hs_hold <= 1'b1;
    else if (!hcmd) hs_hold <= 1'b0;
  end

  assign hs_block = uv_hs | hs_hold;
  assign lone_hi  = hcmd & ~lcmd;
  assign lone_lo  = lcmd & ~hcmd;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_hi <= 1'b0;
      gate_lo <= 1'b0;
    end else begin
      gate_hi <= lone_hi & ~hs_block & ~kill_all;
      gate_lo <= lone_lo & ~kill_all;
    end
  end
endmodule

// File: rtl/bridge_guard.sv
module bridge_guard #(
  parameter int CLK_MHZ    = 100,
  parameter int FILTER_NS  = 1000,
  parameter int RECOVER_US = 30000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] hi_cmd,
  input  logic [2:0] lo_cmd,
  input  logic       oc_flag,
  input  logic       uv_main,
  input  logic [2:0] uv_hi,
  output logic [2:0] gate_hi,
  output logic [2:0] gate_lo,
  output logic       fault_n
);
  import bridge_guard_pkg::*;

  localparam int FILT_RAW = CLK_MHZ * FILTER_NS / 1000;
  localparam int FILT_CYC = (FILT_RAW < 1) ? 1 : FILT_RAW;
  localparam int REC_RAW  = CLK_MHZ * RECOVER_US;
  localparam int REC_CYC  = (REC_RAW < 1) ? 1 : REC_RAW;
  localparam int CMD_W    = 2 * PHASES;
  localparam int STAT_W   = PHASES + 2;

  logic [CMD_W-1:0]  cmd_s;
  logic [CMD_W-1:0]  cmd_q;
  logic [STAT_W-1:0] stat_s;
  logic [PHASES-1:0] hcmd_q;
  logic [PHASES-1:0] lcmd_q;
  logic [PHASES-1:0] uvh_s;
  logic              oc_s;
  logic              uvm_s;
  logic              fault_act;
  logic              kill_all;

  bg_sync #(.W(CMD_W), .STAGES(2)) u_cmd_sync (
    .clk(clk), .rst(rst), .d({lo_cmd, hi_cmd}), .q(cmd_s)
  );

  bg_sync #(.W(STAT_W), .STAGES(2)) u_stat_sync (
    .clk(clk), .rst(rst), .d({uv_hi, uv_main, oc_flag}), .q(stat_s)
  );

  generate
    for (genvar k = 0; k < CMD_W; k++) begin : g_filt
      bg_qual_filter #(.CYCLES(FILT_CYC)) u_filt (
        .clk(clk), .rst(rst), .d(cmd_s[k]), .q(cmd_q[k])
      );
    end
  endgenerate

  assign hcmd_q = cmd_q[PHASES-1:0];
  assign lcmd_q = cmd_q[CMD_W-1:PHASES];
  assign oc_s   = stat_s[0];
  assign uvm_s  = stat_s[1];
  assign uvh_s  = stat_s[STAT_W-1:2];

  bg_fault_timer #(.RECOVER(REC_CYC)) u_timer (
    .clk(clk), .rst(rst), .trip(oc_s), .active(fault_act)
  );

  assign kill_all = fault_act | uvm_s;

  generate
    for (genvar p = 0; p < PHASES; p++) begin : g_phase
      bg_phase_ctl u_leg (
        .clk(clk), .rst(rst),
        .hcmd(hcmd_q[p]), .lcmd(lcmd_q[p]),
        .uv_hs(uvh_s[p]), .kill_all(kill_all),
        .gate_hi(gate_hi[p]), .gate_lo(gate_lo[p])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) fault_n <= 1'b1;
    else     fault_n <= ~fault_act;
  end
endmodule

// File: rtl/bridge_guard_chk.sv
module bridge_guard_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] gate_hi,
  input logic [2:0] gate_lo,
  input logic       fault_n,
  input logic       oc_s,
  input logic       uvm_s,
  input logic [2:0] uvh_s,
  input logic [2:0] hcmd_q
);
  // R10
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (gate_hi == 3'b000 && gate_lo == 3'b000 && fault_n));

  // R3
  oc_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    oc_s |=> (gate_hi == 3'b000 && gate_lo == 3'b000 && !fault_n));

  // R3
  fault_gates_chk: assert property (@(posedge clk) disable iff (rst)
    !fault_n |-> (gate_hi == 3'b000 && gate_lo == 3'b000));

  // R5
  main_uv_chk: assert property (@(posedge clk) disable iff (rst)
    uvm_s |=> (gate_hi == 3'b000 && gate_lo == 3'b000));

  generate
    for (genvar i = 0; i < 3; i++) begin : g_ph
      // R2
      no_shoot_through_chk: assert property (@(posedge clk) disable iff (rst)
        !(gate_hi[i] && gate_lo[i]));

      // R6
      hs_uv_off_chk: assert property (@(posedge clk) disable iff (rst)
        uvh_s[i] |=> !gate_hi[i]);

      // R7
      hs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(uvh_s[i]) && hcmd_q[i]) |=> !gate_hi[i]);
    end
  endgenerate
endmodule

bind bridge_guard bridge_guard_chk u_chk (
  .clk(clk), .rst(rst), .gate_hi(gate_hi), .gate_lo(gate_lo),
  .fault_n(fault_n), .oc_s(oc_s), .uvm_s(uvm_s), .uvh_s(uvh_s),
  .hcmd_q(hcmd_q)
);

// File: tb/bridge_guard_test.sv
module bridge_guard_test;
  localparam int FILT   = 4;
  localparam int REC    = 60;
  localparam int SETTLE = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] hi_cmd = '0, lo_cmd = '0, uv_hi = '0;
  logic       oc_flag = 1'b0, uv_main = 1'b0;
  logic [2:0] gate_hi, gate_lo;
  logic       fault_n;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [2:0] m_latch = '0;
  logic [2:0] cur_h = '0;
  logic       m_fault = 1'b0;

  always #5 clk = ~clk;

  bridge_guard #(.CLK_MHZ(1), .FILTER_NS(FILT * 1000), .RECOVER_US(REC)) uut (
    .clk(clk), .rst(rst), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd),
    .oc_flag(oc_flag), .uv_main(uv_main), .uv_hi(uv_hi),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .fault_n(fault_n)
  );

  function automatic logic [6:0] expect_out(input logic [2:0] h, input logic [2:0] l,
                                            input logic uvm, input logic [2:0] latch,
                                            input logic flt);
    logic [2:0] gh, gl;
    if (flt) return 7'b000_000_0;
    gh = h & ~l & ~latch & {3{~uvm}};
    gl = l & ~h & {3{~uvm}};
    return {gh, gl, 1'b1};
  endfunction

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [2:0] h, input logic [2:0] l,
                       input logic uvm, input logic [2:0] uvh);
    m_latch = uvh | (m_latch & cur_h & h);
    cur_h   = h;
    hi_cmd  = h; lo_cmd = l; uv_main = uvm; uv_hi = uvh;
    repeat (SETTLE) @(negedge clk);
    check(req, {gate_hi, gate_lo, fault_n}, expect_out(h, l, uvm, m_latch, m_fault));
  endtask

  task automatic count_recovery(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (fault_n == 1'b0 && n < 500);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    int seen;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    // R10 reset state while reset is held
    check("R10", {gate_hi, gate_lo, fault_n}, 7'b000_000_1);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R10", {gate_hi, gate_lo, fault_n}, 7'b000_000_1);

    // R1 lone commands
    apply("R1", 3'b001, 3'b000, 1'b0, 3'b000);
    apply("R1", 3'b000, 3'b010, 1'b0, 3'b000);
    apply("R1", 3'b000, 3'b000, 1'b0, 3'b000);
    apply("R1", 3'b101, 3'b010, 1'b0, 3'b000);
    // R2 both commands in one phase
    apply("R2", 3'b011, 3'b001, 1'b0, 3'b000);
    apply("R2", 3'b111, 3'b111, 1'b0, 3'b000);

    // R3 overcurrent
    apply("R1", 3'b001, 3'b100, 1'b0, 3'b000);
    oc_flag = 1'b1; m_fault = 1'b1;
    apply("R3", 3'b001, 3'b100, 1'b0, 3'b000);
    // R4 exact recovery interval
    oc_flag = 1'b0;
    count_recovery(n);
    check_int("R4 recovery edges", n, REC + 3);
    m_fault = 1'b0;
    check("R4 resume", {gate_hi, gate_lo, fault_n}, 7'b001_100_1);
    // R4 restart of the window by a second sighting
    oc_flag = 1'b1;
    repeat (SETTLE) @(negedge clk);
    oc_flag = 1'b0;
    repeat (30) @(negedge clk);
    check("R4 still in window", {gate_hi, gate_lo, fault_n}, 7'b000_000_0);
    oc_flag = 1'b1;
    repeat (2) @(negedge clk);
    oc_flag = 1'b0;
    count_recovery(n);
    check_int("R4 restarted window", n, REC + 3);

    // R5 / R8 main undervoltage
    apply("R5", 3'b001, 3'b010, 1'b1, 3'b000);
    apply("R5 R8 resume", 3'b001, 3'b010, 1'b0, 3'b000);

    // R6 / R7 high-side undervoltage
    apply("R1", 3'b011, 3'b100, 1'b0, 3'b000);
    apply("R6", 3'b011, 3'b100, 1'b0, 3'b001);
    apply("R7 held off", 3'b011, 3'b100, 1'b0, 3'b000);
    apply("R7 cmd low", 3'b010, 3'b100, 1'b0, 3'b000);
    apply("R7 rearmed", 3'b011, 3'b100, 1'b0, 3'b000);

    // R9 short on pulse is ignored
    apply("R1", 3'b000, 3'b000, 1'b0, 3'b000);
    seen = 0;
    hi_cmd = 3'b100;
    repeat (FILT - 2) @(negedge clk);
    hi_cmd = 3'b000;
    for (int c = 0; c < SETTLE; c++) begin
      @(negedge clk);
      if (gate_hi[2]) seen++;
    end
    check_int("R9 short on pulse", seen, 0);
    // R9 long enough pulse passes
    seen = 0;
    hi_cmd = 3'b100;
    for (int c = 0; c < FILT + 2; c++) begin
      @(negedge clk);
      if (gate_hi[2]) seen++;
    end
    hi_cmd = 3'b000;
    for (int c = 0; c < SETTLE; c++) begin
      @(negedge clk);
      if (gate_hi[2]) seen++;
    end
    check_int("R9 long pulse seen", (seen > 0) ? 1 : 0, 1);
    // R9 short off gap is ignored
    apply("R1", 3'b100, 3'b000, 1'b0, 3'b000);
    seen = 0;
    hi_cmd = 3'b000;
    repeat (FILT - 2) @(negedge clk);
    hi_cmd = 3'b100;
    for (int c = 0; c < SETTLE; c++) begin
      @(negedge clk);
      if (!gate_hi[2]) seen++;
    end
    check_int("R9 short off gap", seen, 0);

    // Random mix covering R1 R2 R5 R6 R7 R8, with R3 R4 episodes
    for (int it = 0; it < 200; it++) begin
      logic [2:0] h, l, uvh;
      logic uvm;
      h   = 3'($urandom);
      l   = 3'($urandom);
      uvm = ($urandom % 8) == 0;
      for (int b = 0; b < 3; b++) uvh[b] = ($urandom % 6) == 0;
      apply("R1 R2 R5 R6 R7 R8 random", h, l, uvm, uvh);
      if (($urandom % 15) == 0) begin
        oc_flag = 1'b1; m_fault = 1'b1;
        apply("R3 random", h, l, uvm, uvh);
        oc_flag = 1'b0;
        repeat (REC - 10) @(negedge clk);
        check("R4 random window", {gate_hi, gate_lo, fault_n}, 7'b000_000_0);
        repeat (20) @(negedge clk);
        m_fault = 1'b0;
        check("R4 random resume", {gate_hi, gate_lo, fault_n},
              expect_out(h, l, uvm, m_latch, 1'b0));
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule